// File: doc/BRIEF.md
# Interrupt Status and Vector Logic

This block collects the event flags of a small serial-bus controller and turns them into one interrupt line. The bus engine sends single-cycle pulses for each event: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, receive overrun, transmit underflow, addressed as slave, address zero and single byte. Each pulse sets a sticky bit in a 16-bit status word. A level input reports whether the bus is busy, and that bit is passed through live. An enable word masks the five service events, and the interrupt output is raised while any enabled event is pending.

Software sees the flags in two ways through one 16-bit register port. The first is the status word, which it clears by writing a one to each bit it wants to clear. The second is a legacy vector register. It returns a small priority code for the most urgent enabled event, and reading it clears that event. Reads return the register contents as they stand before any update in the same cycle.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After synchronous reset the status word (apart from the live busy bit 12), the enable word, the vector code and the interrupt output are all zero.
- R2: An event pulse sets its status bit on the next clock edge, and the bit holds until cleared. The bit positions are: arbitration lost 0, no-ack 1, access ready 2, receive ready 3, transmit ready 4, address zero 8, addressed as slave 9, transmit underflow 10, receive overrun 11, single byte 15. Bits 5 to 7, 13 and 14 always read zero.
- R3: A write to the status register (address 1) clears every latched bit written as 1 and leaves bits written as 0 unchanged.
- R4: An event pulse in the same cycle as a clear of that bit, by status write or by vector read, wins, so the bit is set after the edge.
- R5: Status bit 12 follows the bus-busy input in the same cycle, and status writes do not affect it.
- R6: A write to the enable register (address 0) stores data bits 4:0. Enable bits 15:5 always read zero.
- R7: The interrupt output is high exactly when some status bit 4:0 and the matching enable bit are both set.
- R8: The vector code (address 2) is 0 when no enabled service event is pending. Otherwise it is the lowest pending code: 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready.
- R9: A read of the vector register clears only the status bit of the code it returned, on the next edge. A read that returns 0 clears nothing.
- R10: Read data is combinational from the current register state. Address 0 gives the enable word, 1 the status word, 2 the vector code zero-extended, and 3 gives zero.
- R11: Writes to address 2 or 3 change neither the status word nor the enable word. Reads of addresses 0, 1 and 3 clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_arb_lost | input | 1 | Arbitration-lost pulse |
| evt_no_ack | input | 1 | No-acknowledge pulse |
| evt_acc_rdy | input | 1 | Access-ready pulse |
| evt_rx_rdy | input | 1 | Receive-ready pulse |
| evt_tx_rdy | input | 1 | Transmit-ready pulse |
| evt_rx_ovr | input | 1 | Receive-overrun pulse |
| evt_tx_udf | input | 1 | Transmit-underflow pulse |
| evt_slv_addr | input | 1 | Addressed-as-slave pulse |
| evt_addr_zero | input | 1 | Address-zero pulse |
| evt_single_byte | input | 1 | Single-byte pulse |
| bus_busy | input | 1 | Live bus-busy level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| status_o | output | 16 | Status word |
| enable_o | output | 16 | Enable word |
| vector_o | output | 3 | Current vector code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives a pulse into a bit in the same cycle that software clears it. A design that gave the clear priority would lose the event, and the status word would not match. It fills all five service bits and reads the vector repeatedly. A wrong priority order, or a read that cleared the wrong bit or several bits, would show up as an out-of-order code sequence. It also masks pending events, writes to the vector and spare addresses, and toggles bus busy during status writes. These catch an interrupt that ignores the mask, a write decode that leaks into another register, and a busy bit that was latched instead of passed through live.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_SRC = 5;
    localparam int CODE_W  = $clog2(NUM_SRC + 1);

    localparam int BIT_ARB  = 0;
    localparam int BIT_NACK = 1;
    localparam int BIT_ACC  = 2;
    localparam int BIT_RX   = 3;
    localparam int BIT_TX   = 4;
    localparam int BIT_AZ   = 8;
    localparam int BIT_SLV  = 9;
    localparam int BIT_UDF  = 10;
    localparam int BIT_OVR  = 11;
    localparam int BIT_BUSY = 12;
    localparam int BIT_SB   = 15;

    localparam logic [DATA_W-1:0] LATCH_MASK = 16'h8F1F;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_STATUS = 2'd1,
        RA_VECTOR = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    function automatic logic [DATA_W-1:0] src_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank
    import irqv_pkg::*;
#(
    parameter int                DW    = DATA_W,
    parameter logic [DW-1:0]     LMASK = LATCH_MASK,
    parameter int                BUSY  = BIT_BUSY
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    input  logic          busy_i,
    output logic [DW-1:0] flags_o
);

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (LMASK[i]) begin : g_latch
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= set_i[i] | (q & ~clr_i[i]);
            end
            assign flags_o[i] = q;
        end else if (i == BUSY) begin : g_live
            assign flags_o[i] = busy_i;
        end else begin : g_zero
            assign flags_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
    import irqv_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int CW = CODE_W
) (
    input  logic [NS-1:0] pend_i,
    output logic [CW-1:0] code_o,
    output logic [NS-1:0] sel_o
);

    always_comb begin
        code_o = '0;
        sel_o  = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o = CW'(i + 1);
                sel_o  = '0;
                sel_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqv_regif.sv
module irqv_regif
    import irqv_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NS = NUM_SRC,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_req_t      req_i,
    input  logic [DW-1:0] stat_i,
    input  logic [CW-1:0] code_i,
    input  logic [NS-1:0] sel_i,
    output logic [NS-1:0] en_o,
    output logic [DW-1:0] clr_o,
    output logic [DW-1:0] rdata_o
);

    logic [NS-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)                                     en_q <= '0;
        else if (req_i.wr && req_i.addr == RA_ENABLE) en_q <= req_i.data[NS-1:0];
    end

    always_comb begin
        clr_o = '0;
        if (req_i.wr && req_i.addr == RA_STATUS) clr_o = req_i.data;
        if (req_i.rd && req_i.addr == RA_VECTOR) clr_o[NS-1:0] = clr_o[NS-1:0] | sel_i;
    end

    always_comb begin
        unique case (req_i.addr)
            RA_ENABLE: rdata_o = DW'(en_q);
            RA_STATUS: rdata_o = stat_i;
            RA_VECTOR: rdata_o = DW'(code_i);
            default:   rdata_o = '0;
        endcase
    end

    assign en_o = en_q;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irqv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_arb_lost,
    input  logic                evt_no_ack,
    input  logic                evt_acc_rdy,
    input  logic                evt_rx_rdy,
    input  logic                evt_tx_rdy,
    input  logic                evt_rx_ovr,
    input  logic                evt_tx_udf,
    input  logic                evt_slv_addr,
    input  logic                evt_addr_zero,
    input  logic                evt_single_byte,
    input  logic                bus_busy,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [DATA_W-1:0]   status_o,
    output logic [DATA_W-1:0]   enable_o,
    output logic [CODE_W-1:0]   vector_o,
    output logic                irq_o
);

    logic [DATA_W-1:0]  evt_word;
    logic [DATA_W-1:0]  clr_word;
    logic [NUM_SRC-1:0] en_bits;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] sel;
    reg_req_t           req;

    always_comb begin
        evt_word           = '0;
        evt_word[BIT_ARB]  = evt_arb_lost;
        evt_word[BIT_NACK] = evt_no_ack;
        evt_word[BIT_ACC]  = evt_acc_rdy;
        evt_word[BIT_RX]   = evt_rx_rdy;
        evt_word[BIT_TX]   = evt_tx_rdy;
        evt_word[BIT_OVR]  = evt_rx_ovr;
        evt_word[BIT_UDF]  = evt_tx_udf;
        evt_word[BIT_SLV]  = evt_slv_addr;
        evt_word[BIT_AZ]   = evt_addr_zero;
        evt_word[BIT_SB]   = evt_single_byte;
    end

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr_e'(reg_addr), data: reg_wdata};

    irqv_flag_bank #(.DW(DATA_W), .LMASK(LATCH_MASK), .BUSY(BIT_BUSY)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (evt_word),
        .clr_i   (clr_word),
        .busy_i  (bus_busy),
        .flags_o (status_o)
    );

    assign pend = status_o[NUM_SRC-1:0] & en_bits;

    irqv_prio_enc #(.NS(NUM_SRC), .CW(CODE_W)) u_prio (
        .pend_i (pend),
        .code_o (vector_o),
        .sel_o  (sel)
    );

    irqv_regif #(.DW(DATA_W), .NS(NUM_SRC), .CW(CODE_W)) u_regif (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .stat_i  (status_o),
        .code_i  (vector_o),
        .sel_i   (sel),
        .en_o    (en_bits),
        .clr_o   (clr_word),
        .rdata_o (reg_rdata)
    );

    assign enable_o = DATA_W'(en_bits);
    assign irq_o    = |pend;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irqv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              evt_arb_lost,
    input logic              evt_no_ack,
    input logic              evt_acc_rdy,
    input logic              evt_rx_rdy,
    input logic              evt_tx_rdy,
    input logic              evt_rx_ovr,
    input logic              evt_tx_udf,
    input logic              evt_slv_addr,
    input logic              evt_addr_zero,
    input logic              evt_single_byte,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] status_o,
    input logic [CODE_W-1:0] vector_o,
    input logic              irq_o
);

    logic any_evt, quiet;
    assign any_evt = evt_arb_lost | evt_no_ack | evt_acc_rdy | evt_rx_rdy | evt_tx_rdy |
                     evt_rx_ovr | evt_tx_udf | evt_slv_addr | evt_addr_zero | evt_single_byte;
    assign quiet = !any_evt && !(reg_wr && reg_addr == 2'd1) && !(reg_rd && reg_addr == 2'd2);

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        evt_arb_lost |=> status_o[BIT_ARB]);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(status_o & LATCH_MASK));

    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[BIT_NACK] && !evt_no_ack) |=> !status_o[BIT_NACK]);

    p_evt_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[BIT_RX] && evt_rx_rdy) |=> status_o[BIT_RX]);

    p_irq_vec_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o == (vector_o != '0));

    p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
        vector_o <= CODE_W'(NUM_SRC));

    p_vec_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd2 && vector_o == 3'd1 && !evt_arb_lost) |=> !status_o[BIT_ARB]);

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .evt_arb_lost    (evt_arb_lost),
    .evt_no_ack      (evt_no_ack),
    .evt_acc_rdy     (evt_acc_rdy),
    .evt_rx_rdy      (evt_rx_rdy),
    .evt_tx_rdy      (evt_tx_rdy),
    .evt_rx_ovr      (evt_rx_ovr),
    .evt_tx_udf      (evt_tx_udf),
    .evt_slv_addr    (evt_slv_addr),
    .evt_addr_zero   (evt_addr_zero),
    .evt_single_byte (evt_single_byte),
    .reg_wr          (reg_wr),
    .reg_rd          (reg_rd),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .status_o        (status_o),
    .vector_o        (vector_o),
    .irq_o           (irq_o)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;

    localparam logic [15:0] LMASK = 16'h8F1F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ev = '0;
    logic        bsy = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, status, enable;
    logic [2:0]  vector;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_stat = '0;
    logic [15:0] m_en = '0;

    always #5 clk = ~clk;

    irq_vec_ctrl dut_i (
        .clk(clk), .rst(rst),
        .evt_arb_lost(ev[0]), .evt_no_ack(ev[1]), .evt_acc_rdy(ev[2]),
        .evt_rx_rdy(ev[3]), .evt_tx_rdy(ev[4]), .evt_rx_ovr(ev[11]),
        .evt_tx_udf(ev[10]), .evt_slv_addr(ev[9]), .evt_addr_zero(ev[8]),
        .evt_single_byte(ev[15]), .bus_busy(bsy),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .status_o(status), .enable_o(enable),
        .vector_o(vector), .irq_o(irq)
    );

    function automatic logic [2:0] exp_vec(logic [15:0] s, logic [15:0] e);
        logic [4:0] p;
        p = s[4:0] & e[4:0];
        for (int i = 0; i < 5; i++) if (p[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    function automatic logic [15:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return m_en;
            2'd1: return m_stat | (16'(bsy) << 12);
            2'd2: return 16'(exp_vec(m_stat, m_en));
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R2 R3 R4 R9 status"}, status & LMASK, m_stat);
        chk({tag, " R5 busy"}, 16'(status[12]), 16'(bsy));
        chk({tag, " R6 enable"}, enable, m_en);
        chk({tag, " R8 vector"}, 16'(vector), 16'(exp_vec(m_stat, m_en)));
        chk({tag, " R7 irq"}, 16'(irq), 16'(|(m_stat[4:0] & m_en[4:0])));
    endtask

    // One clock: drive at the falling edge, check read data, then check state after the edge.
    task automatic cycle(input logic [15:0] e, input logic b, input logic w, input logic r,
                         input logic [1:0] a, input logic [15:0] d, input string tag);
        logic [15:0] clr;
        logic [2:0]  c;
        ev = e & LMASK; bsy = b; wr = w; rd = r; addr = a; wdata = d;
        #1;
        chk({tag, " R10 rdata"}, rdata, exp_rd(a));
        chk({tag, " R5 live busy"}, 16'(status[12]), 16'(b));
        clr = '0;
        if (w && a == 2'd1) clr = d;
        c = exp_vec(m_stat, m_en);
        if (r && a == 2'd2 && c != 0) clr[c - 1] = 1'b1;
        m_stat = ((m_stat & ~clr) | (e & LMASK)) & LMASK;
        if (w && a == 2'd0) m_en = d & 16'h001F;
        @(posedge clk);
        @(negedge clk);
        ev = '0; wr = 1'b0; rd = 1'b0;
        #1;
        check_outputs(tag);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_outputs("R1 reset");

        // R2: every latched event position, enable still zero so no irq
        cycle(LMASK, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R2 all events");
        chk("R7 masked irq", 16'(irq), 16'h0);
        // R6: upper enable bits dropped
        cycle('0, 1'b1, 1'b1, 1'b0, 2'd0, 16'hFFFF, "R6 enable write");
        chk("R6 upper zero", enable & 16'hFFE0, 16'h0);
        // R11: writes to vector and spare addresses ignored
        cycle('0, 1'b1, 1'b1, 1'b0, 2'd2, 16'hFFFF, "R11 vec write");
        cycle('0, 1'b0, 1'b1, 1'b0, 2'd3, 16'hFFFF, "R11 spare write");
        cycle('0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0, "R11 status read");
        // R8 R9: drain vector in priority order
        for (int k = 1; k <= 5; k++) begin
            chk("R8 order", 16'(vector), 16'(k));
            cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0, "R9 vector read");
        end
        chk("R9 drained", 16'(vector), 16'h0);
        cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0, "R9 empty read");
        // R3: W1C of upper bits, zeros keep
        cycle('0, 1'b1, 1'b1, 1'b0, 2'd1, 16'h0C00, "R3 w1c partial");
        chk("R3 kept", status & 16'h8300, 16'h8300);
        // R4: event vs write clear and vs vector read
        cycle(16'h0008, 1'b0, 1'b1, 1'b0, 2'd1, 16'hFFFF, "R4 evt vs write");
        chk("R4 rx kept", 16'(status[3]), 16'h1);
        cycle(16'h0008, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0, "R4 evt vs read");
        chk("R4 rx kept after read", 16'(status[3]), 16'h1);

        for (int n = 0; n < 3000; n++) begin
            logic [15:0] e;
            e = '0;
            for (int b = 0; b < 16; b++) if ($urandom_range(0, 7) == 0) e[b] = 1'b1;
            cycle(e, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 2) == 0), 2'($urandom_range(0, 3)),
                  16'($urandom), "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule